// File: doc/BRIEF.md
# Non-Volatile Write Enable Sequencer

The block holds the control registers of a byte-wide data EEPROM: a 9-bit address register, an 8-bit data register and three control actions (arm, write strobe, read strobe). All three are reached through one simple register write port. It also contains a behavioural model of the EEPROM array with a configurable write latency.

A write to the array needs a timed two-step unlock. Software first arms the block with a control write that sets the arm bit and leaves the strobe bit clear. That arm bit clears itself after a fixed number of cycles. A strobe that arrives while the arm bit still reads one starts the write. A strobe that arrives at any other time does nothing.

No write starts while flash self-programming is active. A write that has started always finishes, even if reset is asserted while it runs. While the write runs, a busy flag and an oscillator-hold flag stay high. When the write finishes, a one-cycle completion pulse is raised. A sleep controller can watch the oscillator-hold flag and delay a full power-down until it drops.

Top module: `nvw_seq`

## Requirements
- R1: After reset the address register and the data register read 0. A register write with select 0 loads the address from bits [8:0]. A register write with select 1 loads the data register from bits [7:0]. Each takes effect one cycle after the write.
- R2: A control write (select 2) with bit 2 = 1 and bit 1 = 0 sets `arm_q`. `arm_q` then reads 1 for exactly 4 cycles and clears by itself. A repeated arm write reloads the 4-cycle window.
- R3: A control write with bit 1 = 1 and bit 2 = 0 starts a write only if all of these hold: `arm_q` is 1, `busy` is 0 and `spm_active` is 0. When it starts, `busy` rises the next cycle, and the address and data are captured at that edge.
- R4: A strobe while `arm_q` is 0 has no effect. A control write that sets bit 1 and bit 2 together starts no write and leaves `arm_q` unchanged.
- R5: While `spm_active` is 1, a strobe starts no write.
- R6: Reset clears the address, data and arm registers. A write in progress still finishes: the array is updated and `done_irq` still pulses.
- R7: `busy` stays 1 for WR_LAT (6) cycles. It then falls, the captured byte is written to the captured address, and `done_irq` is 1 for exactly the cycle in which `busy` first reads 0.
- R8: A control write with bit 0 = 1 loads the data register from the array at the current address one cycle later. It does this only when `busy` is 0 and the same write starts no write. While `busy` is 1 the read strobe is ignored.
- R9: `osc_hold` is 1 exactly while a write is in progress.
- R10: A strobe while `busy` is 1 neither restarts nor extends the write in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the register state |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 address, 1 data, 2 control |
| reg_wdata | input | 9 | Write data; for control writes: bit0 read, bit1 write strobe, bit2 arm |
| spm_active | input | 1 | Flash self-programming is in progress |
| addr_q | output | 9 | Address register |
| data_q | output | 8 | Data register |
| arm_q | output | 1 | Write window open |
| busy | output | 1 | Write in progress |
| done_irq | output | 1 | One-cycle pulse when a write finishes |
| osc_hold | output | 1 | Oscillator must keep running |

## Verification
Register and arm writes are visible one cycle after the edge that samples them. `busy` rises one cycle after an accepted strobe and falls WR_LAT cycles later, together with the `done_irq` pulse. A read strobe shows the array byte in the data register on the following cycle. The bench drives stimulus just after a rising edge and updates its reference model on that same edge, so model and design move in step. All outputs are compared at the falling edge, half a cycle after the registers settle. The directed checks are placed right after the edge that should or should not have started a write.

// File: rtl/nvw_seq.sv
`timescale 1ns/1ps
module nvw_seq #(
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 8,
  parameter int ARM_WIN = 4,
  parameter int WR_LAT  = 6,
  localparam int WD_W   = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [WD_W-1:0]   reg_wdata,
  input  logic              spm_active,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              arm_q,
  output logic              busy,
  output logic              done_irq,
  output logic              osc_hold
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int AC_W  = $clog2(ARM_WIN + 1);
  localparam int LC_W  = $clog2(WR_LAT + 1);
  localparam logic [1:0] SEL_ADDR = 2'd0, SEL_DATA = 2'd1, SEL_CTRL = 2'd2;

  logic [AC_W-1:0]   arm_cnt;
  logic [LC_W-1:0]   lat_cnt  = '0;
  logic              done_r   = 1'b0;
  logic [ADDR_W-1:0] cap_addr = '0;
  logic [DATA_W-1:0] cap_data = '0;
  logic [DATA_W-1:0] mem [DEPTH];

  wire ctl_wr  = reg_we && (reg_sel == SEL_CTRL);
  wire rd_bit  = reg_wdata[0];
  wire st_bit  = reg_wdata[1];
  wire arm_bit = reg_wdata[2];

  assign arm_q    = (arm_cnt != '0);
  assign busy     = (lat_cnt != '0);
  assign osc_hold = busy;
  assign done_irq = done_r;

  wire start = rst_n && ctl_wr && st_bit && !arm_bit && arm_q && !busy && !spm_active;
  wire rd_go = ctl_wr && rd_bit && !busy && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      arm_cnt <= '0;
    end else begin
      if (reg_we && reg_sel == SEL_ADDR) addr_q <= reg_wdata[ADDR_W-1:0];
      if (reg_we && reg_sel == SEL_DATA) data_q <= reg_wdata[DATA_W-1:0];
      else if (rd_go)                    data_q <= mem[addr_q];
      if (ctl_wr && arm_bit && !st_bit)  arm_cnt <= AC_W'(ARM_WIN);
      else if (arm_q)                    arm_cnt <= arm_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    done_r <= 1'b0;
    if (start) begin
      lat_cnt  <= LC_W'(WR_LAT);
      cap_addr <= addr_q;
      cap_data <= data_q;
    end else if (busy) begin
      lat_cnt <= lat_cnt - 1'b1;
      if (lat_cnt == LC_W'(1)) begin
        mem[cap_addr] <= cap_data;
        done_r        <= 1'b1;
      end
    end
  end

  // R2
  arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm_q) |=> arm_q);
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && st_bit && !arm_bit && arm_q && !busy && !spm_active) |=> busy);
  // R4
  no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && st_bit && !arm_q && !busy) |=> !busy);
  // R5
  spm_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spm_active && !busy) |=> !busy);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !busy);
  // R8
  rd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_wr && rd_bit) |=> $stable(data_q));
endmodule

// File: tb/nvw_seq_test.sv
`timescale 1ns/1ps
module nvw_seq_test;
  localparam int WR_LAT  = 6;
  localparam int ARM_WIN = 4;

  logic       clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, spm_active = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [8:0] reg_wdata = 9'd0;
  logic [8:0] addr_q;
  logic [7:0] data_q;
  logic       arm_q, busy, done_irq, osc_hold;

  always #2.5 clk = ~clk;

  nvw_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .spm_active(spm_active), .addr_q(addr_q),
    .data_q(data_q), .arm_q(arm_q), .busy(busy), .done_irq(done_irq),
    .osc_hold(osc_hold)
  );

  int vecs = 0, errs = 0;
  bit fin = 0;
  int m_addr = 0, m_data = 0, arm_left = 0, lat_left = 0, m_done = 0;
  int cap_a = 0, cap_d = 0;
  int mem [int];

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge rst_n) begin
    m_addr = 0; m_data = 0; arm_left = 0;
  end

  always @(posedge clk) begin
    bit ctl, go, rd, was_busy;
    ctl      = rst_n && reg_we && reg_sel == 2'd2;
    was_busy = lat_left > 0;
    go = ctl && reg_wdata[1] && !reg_wdata[2] && arm_left > 0 && !was_busy && !spm_active;
    rd = ctl && reg_wdata[0] && !was_busy && !go;
    m_done = 0;
    if (was_busy) begin
      lat_left--;
      if (lat_left == 0) begin
        mem[cap_a] = cap_d;
        m_done = 1;
      end
    end
    if (go) begin
      cap_a = m_addr; cap_d = m_data; lat_left = WR_LAT;
    end
    if (!rst_n) begin
      m_addr = 0; m_data = 0; arm_left = 0;
    end else begin
      if (ctl && reg_wdata[2] && !reg_wdata[1]) arm_left = ARM_WIN;
      else if (arm_left > 0) arm_left--;
      if (reg_we && reg_sel == 2'd0) m_addr = reg_wdata;
      if (reg_we && reg_sel == 2'd1) m_data = reg_wdata & 255;
      else if (rd) m_data = mem.exists(m_addr) ? mem[m_addr] : 0;
    end
  end

  always @(negedge clk) begin
    chk("R1 addr", addr_q, m_addr);
    chk("R8 data", data_q, m_data);
    chk("R2 arm", arm_q, arm_left > 0);
    chk("R7 busy", busy, lat_left > 0);
    chk("R7 done", done_irq, m_done);
    chk("R9 osc", osc_hold, lat_left > 0);
  end

  task automatic wr(input logic [1:0] sel, input int val);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val[8:0];
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    chk("R1 reset addr", addr_q, 0);
    chk("R1 reset data", data_q, 0);
    chk("R7 reset busy", busy, 0);

    // R3 basic armed write, R8 readback
    wr(0, 5); wr(1, 'hA5); wr(2, 4); wr(2, 2);
    chk("R3 start", busy, 1);
    idle(WR_LAT);
    chk("R7 end", busy, 0);
    wr(1, 0); wr(2, 1);
    chk("R8 readback", data_q, 'hA5);

    // R4 strobe without arm, and arm with strobe together
    wr(0, 6); wr(1, 'h3C); wr(2, 2);
    chk("R4 no arm", busy, 0);
    wr(2, 6);
    chk("R4 both bits arm", arm_q, 0);
    chk("R4 both bits busy", busy, 0);

    // R2 window expired, then last cycle of window
    wr(2, 4); idle(4); wr(2, 2);
    chk("R2 expired", busy, 0);
    wr(2, 4); idle(3); wr(2, 2);
    chk("R2 last window", busy, 1);
    idle(WR_LAT);
    wr(2, 1);
    chk("R8 addr6", data_q, 'h3C);

    // R5 self-programming blocks
    spm_active = 1'b1;
    wr(2, 4); wr(2, 2);
    chk("R5 spm", busy, 0);
    spm_active = 1'b0;
    idle(5);

    // R10, R8 during busy, R6 reset mid-write, address 511
    wr(0, 511); wr(1, 'h5A); wr(2, 4); wr(2, 2);
    wr(1, 'hFF); wr(2, 1);
    chk("R8 read ignored", data_q, 'hFF);
    wr(2, 4); wr(2, 2);
    chk("R10 still busy", busy, 1);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    chk("R6 addr cleared", addr_q, 0);
    idle(WR_LAT);
    chk("R6 idle", busy, 0);
    wr(0, 511); wr(2, 1);
    chk("R6 write survived", data_q, 'h5A);
    wr(0, 5); wr(2, 1);
    chk("R7 other byte kept", data_q, 'hA5);

    idle(3);
    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #100000;
    if (!fin) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule